// File: doc/BRIEF.md
# Subtract-Until-Equal Greatest Common Divisor Engine

This block is a small hardwired processor that reduces two unsigned operands to their greatest common divisor by repeated subtraction. Two working registers are loaded from the operand inputs. On each pass, a comparator decides which register holds the larger value. An ALU then subtracts the smaller value from the larger, and the difference is written back over the larger register. The loop stops when the registers match or when either register is zero. The first register's value is then placed on a result bus, and a completion flag is raised.

The design is split into two parts. A six-state controller issues a fixed control word in every state. A datapath holds the two operand registers, their input multiplexers, the ALU and the comparator. A reset pulse starts a new computation. The result bus is high-impedance except in the finished state, so several such engines can share one set of wires.

Top module: `subgcd_engine`

## Requirements
- R1: While `rst` is high, `done` is 0 and `resultBus` is high-impedance.
- R2: The operands are captured on the second rising edge after `rst` falls. Any change on `opA` or `opB` after that edge has no effect on the result.
- R3: When both operands are equal and nonzero, the result is that common value.
- R4: For nonzero operands, the result is their greatest common divisor. On each pass, the larger register is replaced by its difference with the smaller one, so that register strictly decreases.
- R5: If `opA` is zero, the result is 0. If only `opB` is zero, the result is `opA`. In both cases no subtraction takes place.
- R6: `done` rises exactly 3 + 2k rising edges after `rst` falls. Here k is the number of subtractions the operand pair needs: one compare cycle and one subtract cycle per pass, plus a clear cycle, a load cycle and a final compare cycle.
- R7: Once `done` is high, it stays high and `resultBus` holds its value until `rst` is raised again.
- R8: `resultBus` is high-impedance in every cycle before `done` rises. It carries the result while `done` is high.
- R9: Raising `rst` in the middle of a computation abandons it. `done` stays low, and the next run after reset yields the correct result for its own operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rst | input | 1 | Synchronous reset; holds the engine in its clear state |
| opA | input | WIDTH | First operand, loaded into the first register |
| opB | input | WIDTH | Second operand, loaded into the second register |
| resultBus | output | WIDTH | First register value while finished, high-impedance otherwise |
| done | output | 1 | High once the computation has finished |

## Verification
The bench goes after the zero-operand cases. A controller without the zero exit would loop forever subtracting zero, and the bench reports this through its latency bound. It also checks operand order: if the greater-than flag were inverted, the smaller register would be subtracted from and would wrap, giving a wrong result. Exact cycle counts are checked against a count of subtractions computed from a division-based Euclid sequence, which exposes an extra or missing state in the loop. Operand inputs are scrambled right after the load edge, and one run is interrupted by reset, so the bench can detect a register that reloads late or a run that is not cleanly abandoned.

// File: rtl/subgcd_pkg.sv
package subgcd_pkg;

  // Controller states; numeric codes follow the six-step sequence.
  typedef enum logic [2:0] {
    ST_LOAD = 3'd0,
    ST_CMP  = 3'd1,
    ST_SUBX = 3'd2,
    ST_SUBY = 3'd3,
    ST_DONE = 3'd4,
    ST_CLR  = 3'd5
  } state_e;

  // ALU operation codes.
  typedef enum logic [2:0] {
    ALU_PASSA = 3'b000,
    ALU_PASSB = 3'b001,
    ALU_SUB   = 3'b101
  } alu_op_e;

  // Control word from controller to datapath.
  typedef struct packed {
    logic    xFromIn;
    logic    yFromIn;
    logic    xLoad;
    logic    yLoad;
    alu_op_e aluOp;
    logic    outEn;
    logic    xMinusY;
    logic    clear;
    logic    done;
  } ctrl_word_t;

  // Comparator status back to the controller.
  typedef struct packed {
    logic eq;
    logic gt;
    logic xZero;
    logic yZero;
  } cmp_flags_t;

endpackage

// File: rtl/subgcd_alu.sv
module subgcd_alu
  import subgcd_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] xVal,
  input  logic [WIDTH-1:0] yVal,
  input  alu_op_e          op,
  input  logic             xMinusY,
  output logic [WIDTH-1:0] res
);

  logic [WIDTH-1:0] lhs;
  logic [WIDTH-1:0] rhs;

  // The order bit picks which register is the minuend.
  always_comb begin
    lhs = xMinusY ? xVal : yVal;
    rhs = xMinusY ? yVal : xVal;
  end

  always_comb begin
    unique case (op)
      ALU_PASSA: res = xVal;
      ALU_PASSB: res = yVal;
      ALU_SUB:   res = lhs - rhs;
      default:   res = '0;
    endcase
  end

endmodule

// File: rtl/subgcd_cmp.sv
module subgcd_cmp
  import subgcd_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] xVal,
  input  logic [WIDTH-1:0] yVal,
  output cmp_flags_t       flags
);

  always_comb begin
    flags.eq    = (xVal == yVal);
    flags.gt    = (xVal > yVal);
    flags.xZero = (xVal == '0);
    flags.yZero = (yVal == '0);
  end

endmodule

// File: rtl/subgcd_datapath.sv
module subgcd_datapath
  import subgcd_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrl_word_t       word,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] xOut,
  output cmp_flags_t       flags
);

  logic [WIDTH-1:0] xReg;
  logic [WIDTH-1:0] yReg;
  logic [WIDTH-1:0] aluRes;
  logic [WIDTH-1:0] xNext;
  logic [WIDTH-1:0] yNext;

  subgcd_alu #(.WIDTH(WIDTH)) u_alu (
    .xVal    (xReg),
    .yVal    (yReg),
    .op      (word.aluOp),
    .xMinusY (word.xMinusY),
    .res     (aluRes)
  );

  subgcd_cmp #(.WIDTH(WIDTH)) u_cmp (
    .xVal  (xReg),
    .yVal  (yReg),
    .flags (flags)
  );

  // Each register takes either its external operand or the ALU result.
  always_comb begin
    xNext = word.xFromIn ? opA : aluRes;
    yNext = word.yFromIn ? opB : aluRes;
  end

  always_ff @(posedge clk) begin
    if (rst || word.clear) begin
      xReg <= '0;
      yReg <= '0;
    end else begin
      if (word.xLoad) xReg <= xNext;
      if (word.yLoad) yReg <= yNext;
    end
  end

  assign xOut = xReg;

  // R4: a write-back of a difference always shrinks the register written.
  a_r4_x_shrinks: assert property (@(posedge clk) disable iff (rst)
    (word.xLoad && !word.xFromIn) |=> (xReg < $past(xReg)));
  a_r4_y_shrinks: assert property (@(posedge clk) disable iff (rst)
    (word.yLoad && !word.yFromIn) |=> (yReg < $past(yReg)));

  // R5: the output is enabled only when a stop condition holds.
  a_r5_stop_condition: assert property (@(posedge clk) disable iff (rst)
    word.outEn |-> (flags.eq || flags.xZero || flags.yZero));

endmodule

// File: rtl/subgcd_ctrl.sv
module subgcd_ctrl
  import subgcd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  cmp_flags_t flags,
  output ctrl_word_t word
);

  state_e state;
  state_e nxt;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_CLR;
    else     state <= nxt;
  end

  always_comb begin
    unique case (state)
      ST_CLR:  nxt = ST_LOAD;
      ST_LOAD: nxt = ST_CMP;
      ST_CMP: begin
        if (flags.eq || flags.xZero || flags.yZero) nxt = ST_DONE;
        else if (flags.gt)                          nxt = ST_SUBX;
        else                                        nxt = ST_SUBY;
      end
      ST_SUBX: nxt = ST_CMP;
      ST_SUBY: nxt = ST_CMP;
      ST_DONE: nxt = ST_DONE;
      default: nxt = ST_CLR;
    endcase
  end

  // One fixed control word per state.
  always_comb begin
    word         = '0;
    word.aluOp   = ALU_SUB;
    unique case (state)
      ST_CLR: begin
        word.xFromIn = 1'b1;
        word.yFromIn = 1'b1;
        word.clear   = 1'b1;
      end
      ST_LOAD: begin
        word.xFromIn = 1'b1;
        word.yFromIn = 1'b1;
        word.xLoad   = 1'b1;
        word.yLoad   = 1'b1;
      end
      ST_SUBX: begin
        word.xMinusY = 1'b1;
        word.xLoad   = 1'b1;
      end
      ST_SUBY: begin
        word.yLoad   = 1'b1;
      end
      ST_DONE: begin
        word.outEn   = 1'b1;
        word.done    = 1'b1;
      end
      default: ;
    endcase
  end

  // R7: the finished state is left only through reset.
  a_r7_done_sticky: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DONE) |=> (state == ST_DONE));

  // R2: the load is followed by exactly one compare.
  a_r2_load_then_compare: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LOAD) |=> (state == ST_CMP));

  // R6: every subtract cycle returns to compare.
  a_r6_sub_returns: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SUBX || state == ST_SUBY) |=> (state == ST_CMP));

endmodule

// File: rtl/subgcd_engine.sv
module subgcd_engine
  import subgcd_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] resultBus,
  output logic             done
);

  ctrl_word_t       word;
  cmp_flags_t       flags;
  logic [WIDTH-1:0] xOut;

  subgcd_ctrl u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .flags (flags),
    .word  (word)
  );

  subgcd_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk   (clk),
    .rst   (rst),
    .word  (word),
    .opA   (opA),
    .opB   (opB),
    .xOut  (xOut),
    .flags (flags)
  );

  assign resultBus = word.outEn ? xOut : 'z;
  assign done      = word.done;

  // R8: while finished, the driven value does not move.
  a_r8_bus_stable: assert property (@(posedge clk) disable iff (rst)
    (done && $past(done)) |-> $stable(xOut));

endmodule

// File: tb/subgcd_engine_tb.sv
`timescale 1ns/1ps
module subgcd_engine_tb;

  localparam int W        = 8;
  localparam int MAXEDGES = 700;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  wire  [W-1:0] resultBus;
  wire          done;

  int nChecks = 0;
  int nFails  = 0;

  always #2.5 clk = ~clk;

  subgcd_engine #(.WIDTH(W)) u_dut (
    .clk       (clk),
    .rst       (rst),
    .opA       (opA),
    .opB       (opB),
    .resultBus (resultBus),
    .done      (done)
  );

  // A released bus reads as all-z, or as zero on two-state simulators.
  function automatic bit busReleased();
    return (resultBus === {W{1'bz}}) || (resultBus === {W{1'b0}});
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected result and subtraction count, from division-based Euclid.
  task automatic expected(input int a, input int b, output int res, output int k);
    int p = a;
    int q = b;
    k = 0;
    if (a == 0 || b == 0) begin
      res = a;
    end else begin
      while (q != 0) begin
        int r;
        k += p / q;
        r = p % q;
        p = q;
        q = r;
      end
      res = p;
      k -= 1;
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    // R1: idle under reset
    check(done == 1'b0, "R1 done low in reset", done, 0);
    check(busReleased(), "R1 bus released in reset", resultBus, 0);
  endtask

  task automatic runPair(input int a, input int b, input bit scramble);
    int expRes, expK, edges, heldVal;
    expected(a, b, expRes, expK);
    opA = a[W-1:0];
    opB = b[W-1:0];
    doReset();
    rst = 1'b0;
    edges = 0;
    for (int i = 0; i < MAXEDGES; i++) begin
      @(posedge clk);
      #1;
      edges++;
      // R2: inputs after the load edge must not matter
      if (edges == 2 && scramble) begin
        opA = ~a[W-1:0];
        opB = a[W-1:0] ^ 8'h5a;
      end
      if (done) break;
      // R8: released before completion
      if (!busReleased()) check(1'b0, "R8 bus driven early", resultBus, 0);
    end
    nChecks++;
    // R6: exact latency
    check(done && edges == 3 + 2 * expK, "R6 latency", edges, 3 + 2 * expK);
    // R3 R4 R5: result value
    if (a == 0 || b == 0)
      check(resultBus === expRes[W-1:0], "R5 zero operand result", resultBus, expRes);
    else if (a == b)
      check(resultBus === expRes[W-1:0], "R3 equal operands result", resultBus, expRes);
    else
      check(resultBus === expRes[W-1:0], "R4 gcd result", resultBus, expRes);
    // R7: hold until reset
    heldVal = resultBus;
    for (int j = 0; j < 3; j++) begin
      @(posedge clk);
      #1;
      opA = opA + 8'd17;
    end
    check(done == 1'b1 && resultBus == heldVal[W-1:0], "R7 done and result held",
          resultBus, heldVal);
  endtask

  initial begin
    #(5.0 * 190000);
    nFails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    doReset();
    // Near-exhaustive sweep over small operands, including zeros
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        runPair(a, b, (a + b) % 2 == 1);
    // Boundary operands
    runPair(255, 1, 1'b1);
    runPair(1, 255, 1'b1);
    runPair(255, 255, 1'b0);
    runPair(0, 255, 1'b1);
    runPair(200, 0, 1'b1);
    runPair(200, 120, 1'b1);
    runPair(144, 233, 1'b0);
    // R9: reset mid-computation
    opA = 8'd255;
    opB = 8'd1;
    doReset();
    rst = 1'b0;
    for (int i = 0; i < 40; i++) @(posedge clk);
    #1;
    check(done == 1'b0, "R9 still running before abort", done, 0);
    doReset();
    check(done == 1'b0, "R9 abort clears done", done, 0);
    runPair(36, 24, 1'b1);
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule